// File: doc/BRIEF.md
# Dual-Space I2C Slave Controller

This block is an I2C bus slave that answers to two 7-bit device identifiers, each opening its own address space. One identifier reaches a byte-wide memory array addressed by a two-byte pointer (high byte first, truncated to the array width). The other reaches a small register file addressed by a one-byte pointer. The block tells the R/W bit apart, loads the pointer of the addressed space on writes, stores write data, and shifts out read data. The active pointer advances by one after every data byte.

Each space keeps its own current-address pointer, and a transaction in one space never moves the other. A memory read that is interrupted by register traffic therefore resumes where it stopped. The bus lines are sampled on the system clock through two-stage synchronizers. SDA is driven through an active-high pull-low enable. Storage sits outside the block behind synchronous ports, with read data valid one clock after the address.

Top module: `dsi_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7:1 equal MEM_ID or REG_ID. For any other identifier it never pulls SDA low and never writes, for either R/W value, until the next Start.
- R2: A write to MEM_ID (R/W bit 0 = write) takes a high address byte, a low address byte, and then data bytes. Every byte is acknowledged. The data lands at consecutive locations starting from {high,low} modulo 2^MEM_AW.
- R3: A write to REG_ID takes a single address byte and then data bytes. Every byte is acknowledged, and the data lands at consecutive register indices.
- R4: A write that only loads an address, followed by a repeated Start and a read (R/W bit 1), returns data from the newly loaded address. No storage write happens.
- R5: A read that opens directly with a read address returns data from the current pointer of that space. The MSB goes out on the SCL clock right after the address acknowledge.
- R6: In a read, a master ACK (SDA low in the ninth clock) fetches the next byte at pointer+1. A master NACK ends the transfer, and the slave keeps SDA released from then on.
- R7: The two pointers are independent. Accessing one space leaves the other pointer unchanged.
- R8: The memory pointer wraps from 2^MEM_AW-1 to 0, and the register pointer wraps from REG_COUNT-1 to 0. A register address whose low $clog2(REG_COUNT) bits are at or above REG_COUNT loads index 0.
- R9: A Start or Stop in the middle of a byte abandons that byte. A partly received address or data byte loads nothing and writes nothing, and both pointers keep their values.
- R10: The SDA enable changes only while SCL is low. It is high only in acknowledge slots or for 0 bits of read data.
- R11: After reset, the SDA enable and both write strobes are low, and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr | output | MEM_AW | Memory address (current memory pointer) |
| mem_we | output | 1 | Memory write strobe, one clock |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_addr |
| reg_addr | output | $clog2(REG_COUNT) | Register index (current register pointer) |
| reg_we | output | 1 | Register write strobe, one clock |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one clock after reg_addr |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except when it makes Start and Stop. It never makes a Start or Stop while the slave holds SDA low. It keeps each SCL phase several system clocks long, so the synchronized SDA has settled before each synchronized SCL edge. The bench master changes SDA a quarter bit after each SCL fall and holds every SCL level for ten system clocks. Its mid-byte aborts fall on bits where the slave is not driving.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WDAT,
    PH_RDAT,
    PH_SKIP
  } phase_e;

  typedef enum logic {
    SP_MEM,
    SP_REG
  } space_e;
endpackage

// File: rtl/dsi_rst_sync.sv
module dsi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/dsi_line_mon.sv
module dsi_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic [2:0] scl_q, sda_q;
  logic [2:0] scl_d, sda_d;

  always_comb begin
    scl_d = {scl_q[1:0], scl_i};
    sda_d = {sda_q[1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  assign scl_lvl  = scl_q[1];
  assign sda_lvl  = sda_q[1];
  assign ev_rise  = scl_q[1] & ~scl_q[2];
  assign ev_fall  = ~scl_q[1] & scl_q[2];
  assign ev_start = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign ev_stop  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/dsi_ptr.sv
module dsi_ptr #(
  parameter int AW    = 4,
  parameter int COUNT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [15:0]   load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(COUNT - 1);

  logic [AW-1:0] ptr_d;
  logic [AW-1:0] trunc;
  logic          unused_hi;

  assign trunc     = load_val[AW-1:0];
  assign unused_hi = ^load_val[15:AW];

  always_comb begin
    ptr_d = ptr;
    if (load)     ptr_d = (trunc > LAST) ? '0 : trunc;
    else if (inc) ptr_d = (ptr == LAST) ? '0 : ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R8: pointer never leaves the legal index range
  p_ptr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST) else $error("pointer out of range");

  // R9: with no load and no increment the pointer keeps its value
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(ptr)) else $error("pointer moved without request");
endmodule

// File: rtl/dsi_i2c_slave.sv
module dsi_i2c_slave
  import dsi_pkg::*;
#(
  parameter logic [6:0] MEM_ID    = 7'h50,
  parameter logic [6:0] REG_ID    = 7'h68,
  parameter int         MEM_AW    = 10,
  parameter int         REG_COUNT = 24,
  localparam int        REG_AW    = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_we,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam int MEM_COUNT = 1 << MEM_AW;

  logic rst_sync_n;
  logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;

  dsi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  dsi_line_mon u_line (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .ev_rise(ev_rise), .ev_fall(ev_fall),
    .ev_start(ev_start), .ev_stop(ev_stop)
  );

  phase_e      phase_q, phase_d;
  space_e      space_q, space_d;
  logic [3:0]  cnt_q, cnt_d;
  logic        in_ack_q, in_ack_d;
  logic        mslot_q, mslot_d;
  logic [7:0]  shreg_q, shreg_d;
  logic [7:0]  tx_q, tx_d;
  logic [7:0]  hi_q, hi_d;
  logic        oe_q, oe_d;
  logic        mem_we_q, mem_we_d, reg_we_q, reg_we_d;
  logic [7:0]  wdata_q, wdata_d;
  logic        inc_mem_q, inc_mem_d, inc_reg_q, inc_reg_d;
  logic        ld_mem, ld_reg;
  logic [15:0] ld_val;
  logic [7:0]  rd_byte;
  logic        hit_mem, hit_reg;
  logic [MEM_AW-1:0] mem_ptr;
  logic [REG_AW-1:0] reg_ptr;

  assign rd_byte = (space_q == SP_MEM) ? mem_rdata : reg_rdata;
  assign hit_mem = (shreg_q[7:1] == MEM_ID);
  assign hit_reg = (shreg_q[7:1] == REG_ID);
  assign ld_val  = {(space_q == SP_MEM) ? hi_q : 8'h00, shreg_q};

  always_comb begin
    phase_d   = phase_q;
    space_d   = space_q;
    cnt_d     = cnt_q;
    in_ack_d  = in_ack_q;
    mslot_d   = mslot_q;
    shreg_d   = shreg_q;
    tx_d      = tx_q;
    hi_d      = hi_q;
    oe_d      = oe_q;
    wdata_d   = wdata_q;
    mem_we_d  = 1'b0;
    reg_we_d  = 1'b0;
    inc_mem_d = 1'b0;
    inc_reg_d = 1'b0;
    ld_mem    = 1'b0;
    ld_reg    = 1'b0;
    if (ev_start || ev_stop) begin
      phase_d  = ev_start ? PH_DEV : PH_IDLE;
      cnt_d    = 4'd0;
      in_ack_d = 1'b0;
      mslot_d  = 1'b0;
      oe_d     = 1'b0;
    end else if (phase_q == PH_RDAT) begin
      if (ev_rise) begin
        if (in_ack_q) begin
          if (mslot_q && sda_lvl) begin
            phase_d  = PH_SKIP;
            in_ack_d = 1'b0;
          end
        end else if (cnt_q < 4'd8) begin
          cnt_d = cnt_q + 4'd1;
        end
      end else if (ev_fall) begin
        if (in_ack_q) begin
          tx_d      = {rd_byte[6:0], 1'b0};
          oe_d      = ~rd_byte[7];
          cnt_d     = 4'd0;
          in_ack_d  = 1'b0;
          inc_mem_d = (space_q == SP_MEM);
          inc_reg_d = (space_q == SP_REG);
        end else if (cnt_q == 4'd8) begin
          oe_d     = 1'b0;
          in_ack_d = 1'b1;
          mslot_d  = 1'b1;
        end else begin
          oe_d = ~tx_q[7];
          tx_d = {tx_q[6:0], 1'b0};
        end
      end
    end else if (phase_q inside {PH_DEV, PH_AHI, PH_ALO, PH_WDAT}) begin
      if (ev_rise && !in_ack_q && cnt_q < 4'd8) begin
        shreg_d = {shreg_q[6:0], sda_lvl};
        cnt_d   = cnt_q + 4'd1;
      end else if (ev_fall) begin
        if (in_ack_q) begin
          in_ack_d = 1'b0;
          cnt_d    = 4'd0;
          oe_d     = 1'b0;
        end else if (cnt_q == 4'd8) begin
          in_ack_d = 1'b1;
          oe_d     = 1'b1;
          case (phase_q)
            PH_DEV: begin
              if (hit_mem || hit_reg) begin
                space_d = hit_reg ? SP_REG : SP_MEM;
                mslot_d = 1'b0;
                if (shreg_q[0]) phase_d = PH_RDAT;
                else            phase_d = hit_reg ? PH_ALO : PH_AHI;
              end else begin
                phase_d  = PH_SKIP;
                in_ack_d = 1'b0;
                oe_d     = 1'b0;
              end
            end
            PH_AHI: begin
              hi_d    = shreg_q;
              phase_d = PH_ALO;
            end
            PH_ALO: begin
              ld_mem  = (space_q == SP_MEM);
              ld_reg  = (space_q == SP_REG);
              phase_d = PH_WDAT;
            end
            default: begin
              wdata_d   = shreg_q;
              mem_we_d  = (space_q == SP_MEM);
              reg_we_d  = (space_q == SP_REG);
              inc_mem_d = (space_q == SP_MEM);
              inc_reg_d = (space_q == SP_REG);
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q   <= PH_IDLE;
      space_q   <= SP_MEM;
      cnt_q     <= 4'd0;
      in_ack_q  <= 1'b0;
      mslot_q   <= 1'b0;
      shreg_q   <= 8'h00;
      tx_q      <= 8'h00;
      hi_q      <= 8'h00;
      oe_q      <= 1'b0;
      wdata_q   <= 8'h00;
      mem_we_q  <= 1'b0;
      reg_we_q  <= 1'b0;
      inc_mem_q <= 1'b0;
      inc_reg_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      space_q   <= space_d;
      cnt_q     <= cnt_d;
      in_ack_q  <= in_ack_d;
      mslot_q   <= mslot_d;
      shreg_q   <= shreg_d;
      tx_q      <= tx_d;
      hi_q      <= hi_d;
      oe_q      <= oe_d;
      wdata_q   <= wdata_d;
      mem_we_q  <= mem_we_d;
      reg_we_q  <= reg_we_d;
      inc_mem_q <= inc_mem_d;
      inc_reg_q <= inc_reg_d;
    end
  end

  dsi_ptr #(.AW(MEM_AW), .COUNT(MEM_COUNT)) u_mem_ptr (
    .clk(clk), .rst_n(rst_sync_n), .load(ld_mem), .load_val(ld_val),
    .inc(inc_mem_q), .ptr(mem_ptr)
  );

  dsi_ptr #(.AW(REG_AW), .COUNT(REG_COUNT)) u_reg_ptr (
    .clk(clk), .rst_n(rst_sync_n), .load(ld_reg), .load_val(ld_val),
    .inc(inc_reg_q), .ptr(reg_ptr)
  );

  assign sda_oe    = oe_q;
  assign mem_addr  = mem_ptr;
  assign mem_we    = mem_we_q;
  assign mem_wdata = wdata_q;
  assign reg_addr  = reg_ptr;
  assign reg_we    = reg_we_q;
  assign reg_wdata = wdata_q;

  // R1: an ignored transaction never drives SDA and never writes
  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase_q == PH_SKIP) |-> (!oe_q && !mem_we_q && !reg_we_q))
    else $error("ignored transaction touched the bus or storage");

  // R4: a storage write only follows a data byte received after the address
  p_mem_we_src_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we_q |-> $past(phase_q == PH_WDAT)) else $error("memory write outside data phase");
  p_reg_we_src_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_we_q |-> $past(phase_q == PH_WDAT)) else $error("register write outside data phase");

  // R2: write strobe is a single clock
  p_mem_we_pulse_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we_q |=> !mem_we_q) else $error("memory strobe longer than one clock");

  // R7: the idle space's pointer stays put
  p_reg_ptr_kept_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (space_q == SP_MEM && $past(space_q) == SP_MEM) |-> $stable(reg_ptr))
    else $error("register pointer moved during memory access");
  p_mem_ptr_kept_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (space_q == SP_REG && $past(space_q) == SP_REG) |-> $stable(mem_ptr))
    else $error("memory pointer moved during register access");

  // R10: SDA enable toggles only while SCL is low
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_lvl)) else $error("SDA changed with SCL high");
endmodule

// File: tb/tb_dsi_i2c_slave.sv
`timescale 1ns/1ps
module tb_dsi_i2c_slave;
  localparam int MAW = 6;
  localparam int MSZ = 64;
  localparam int RCNT = 12;
  localparam int RAW = 4;
  localparam int Q = 5;
  localparam logic [6:0] MID = 7'h50;
  localparam logic [6:0] RID = 7'h68;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl, sda_m, sda_line, sda_oe;
  logic [MAW-1:0] mem_addr;
  logic [RAW-1:0] reg_addr;
  logic mem_we, reg_we;
  logic [7:0] mem_wdata, reg_wdata, mem_rdata, reg_rdata;

  assign sda_line = sda_m & ~sda_oe;

  dsi_i2c_slave #(.MEM_ID(MID), .REG_ID(RID), .MEM_AW(MAW), .REG_COUNT(RCNT)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  logic [7:0] st_mem [MSZ];
  logic [7:0] st_reg [16];
  logic [7:0] exp_mem [MSZ];
  logic [7:0] exp_reg [RCNT];
  int exp_mptr, exp_rptr;
  int checks = 0, errors = 0, wr_count = 0, viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;

  always @(posedge clk) begin
    if (mem_we) st_mem[mem_addr] <= mem_wdata;
    if (reg_we) st_reg[reg_addr] <= reg_wdata;
    mem_rdata <= st_mem[mem_addr];
    reg_rdata <= st_reg[reg_addr];
    if (mem_we || reg_we) wr_count <= wr_count + 1;
  end

  always @(negedge clk) begin
    if (scl && prev_scl && (sda_oe != prev_oe)) viol <= viol + 1;
    prev_oe <= sda_oe;
    prev_scl <= scl;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    wq(); sda_m = b; wq(); scl = 1'b1; wq(); s = sda_line; wq(); scl = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  task automatic send_chk(input string tag, input logic [7:0] b);
    logic a;
    send_byte(b, a);
    chk(tag, a, 1);
  endtask

  task automatic rd_bytes(input bit reg_sp, input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      if (reg_sp) begin
        chk(tag, d, exp_reg[exp_rptr]);
        exp_rptr = (exp_rptr + 1) % RCNT;
      end else begin
        chk(tag, d, exp_mem[exp_mptr]);
        exp_mptr = (exp_mptr + 1) % MSZ;
      end
    end
    chk("R6 SDA released after NACK", sda_oe, 0);
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < MSZ; i++) begin st_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    for (int i = 0; i < 16; i++) st_reg[i] = 8'h00;
    for (int i = 0; i < RCNT; i++) exp_reg[i] = 8'h00;
    exp_mptr = 0; exp_rptr = 0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    chk("R11 reset sda_oe", sda_oe, 0);
    chk("R11 reset mem_we", mem_we, 0);
    chk("R11 reset reg_we", reg_we, 0);
    chk("R11 reset mem_addr", mem_addr, 0);
    chk("R11 reset reg_addr", reg_addr, 0);

    // R1: foreign identifiers, write and read
    bus_start();
    send_byte({7'h3C, 1'b0}, a); chk("R1 foreign write id ack", a, 0);
    send_byte(8'hA5, a);          chk("R1 byte after foreign id ack", a, 0);
    bus_stop();
    bus_start();
    send_byte({7'h51, 1'b1}, a);  chk("R1 foreign read id ack", a, 0);
    recv_byte(1'b1, d);           chk("R1 foreign read data idle", d, 8'hFF);
    bus_stop();
    chk("R1 no writes", wr_count, 0);

    // R2: full memory sweep, high address byte truncated
    bus_start();
    send_chk("R2 dev ack", {MID, 1'b0});
    send_chk("R2 addr hi ack", 8'h12);
    send_chk("R2 addr lo ack", 8'h00);
    for (int i = 0; i < MSZ; i++) begin
      exp_mem[i] = 8'((i * 37 + 11) & 255);
      send_byte(exp_mem[i], a);
      if (!a) chk("R2 data ack", a, 1);
    end
    bus_stop();
    exp_mptr = 0;
    for (int i = 0; i < MSZ; i++) chk("R2 memory content", st_mem[i], exp_mem[i]);

    // R8: memory write across the top
    bus_start();
    send_chk("R8 dev ack", {MID, 1'b0});
    send_chk("R8 hi ack", 8'h00);
    send_chk("R8 lo ack", 8'd62);
    for (int k = 0; k < 4; k++) begin
      exp_mem[(62 + k) % MSZ] = 8'hC0 + 8'(k);
      send_chk("R8 data ack", 8'hC0 + 8'(k));
    end
    bus_stop();
    exp_mptr = 2;
    for (int k = 0; k < 4; k++) chk("R8 memory wrap content", st_mem[(62 + k) % MSZ], exp_mem[(62 + k) % MSZ]);

    // R3: full register sweep
    bus_start();
    send_chk("R3 dev ack", {RID, 1'b0});
    send_chk("R3 addr ack", 8'h00);
    for (int i = 0; i < RCNT; i++) begin
      exp_reg[i] = 8'h80 ^ 8'(i * 5);
      send_chk("R3 data ack", exp_reg[i]);
    end
    bus_stop();
    for (int i = 0; i < RCNT; i++) chk("R3 register content", st_reg[i], exp_reg[i]);

    // R8: register wrap and out-of-range address
    bus_start();
    send_chk("R8 reg dev ack", {RID, 1'b0});
    send_chk("R8 reg addr ack", 8'd10);
    for (int k = 0; k < 3; k++) begin
      exp_reg[(10 + k) % RCNT] = 8'h3A + 8'(k);
      send_chk("R8 reg data ack", 8'h3A + 8'(k));
    end
    bus_stop();
    chk("R8 reg wrap idx10", st_reg[10], 8'h3A);
    chk("R8 reg wrap idx11", st_reg[11], 8'h3B);
    chk("R8 reg wrap idx0", st_reg[0], 8'h3C);
    bus_start();
    send_chk("R8 reg dev ack", {RID, 1'b0});
    send_chk("R8 reg high addr ack", 8'h0E);
    send_chk("R8 reg data ack", 8'h77);
    bus_stop();
    exp_reg[0] = 8'h77;
    exp_rptr = 1;
    chk("R8 out-of-range addr to idx0", st_reg[0], 8'h77);

    // R5: current-address memory read
    bus_start();
    send_chk("R5 read dev ack", {MID, 1'b1});
    rd_bytes(1'b0, 2, "R5 current read data");
    bus_stop();

    // R4, R6, R8: selective sequential read across the top
    w0 = wr_count;
    bus_start();
    send_chk("R4 dev ack", {MID, 1'b0});
    send_chk("R4 hi ack", 8'h00);
    send_chk("R4 lo ack", 8'd60);
    bus_start();
    send_chk("R4 read dev ack", {MID, 1'b1});
    exp_mptr = 60;
    rd_bytes(1'b0, 70, "R6 sequential read data");
    bus_stop();
    chk("R4 no write in selective read", wr_count, w0);

    // R7: register access between memory reads
    bus_start();
    send_chk("R7 reg dev ack", {RID, 1'b0});
    send_chk("R7 reg addr ack", 8'd5);
    bus_start();
    send_chk("R7 reg read ack", {RID, 1'b1});
    exp_rptr = 5;
    rd_bytes(1'b1, 2, "R7 reg read data");
    bus_stop();
    bus_start();
    send_chk("R7 mem read ack", {MID, 1'b1});
    rd_bytes(1'b0, 1, "R7 memory resumes");
    bus_stop();
    bus_start();
    send_chk("R7 reg current ack", {RID, 1'b1});
    rd_bytes(1'b1, 1, "R7 register resumes");
    bus_stop();

    // R9: Stop inside a low address byte
    bus_start();
    send_chk("R9 dev ack", {MID, 1'b0});
    send_chk("R9 hi ack", 8'h00);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
    bus_stop();
    bus_start();
    send_chk("R9 read ack", {MID, 1'b1});
    rd_bytes(1'b0, 1, "R9 memory pointer kept");
    bus_stop();

    // R9: repeated Start inside a register address byte
    bus_start();
    send_chk("R9 reg dev ack", {RID, 1'b0});
    for (int k = 0; k < 4; k++) clk_bit(1'b0, s);
    bus_start();
    send_chk("R9 reg read ack", {RID, 1'b1});
    rd_bytes(1'b1, 1, "R9 register pointer kept");
    bus_stop();

    // R9: Stop inside a data byte writes nothing
    w0 = wr_count;
    bus_start();
    send_chk("R9 dev ack", {MID, 1'b0});
    send_chk("R9 hi ack", 8'h00);
    send_chk("R9 lo ack", 8'd40);
    exp_mptr = 40;
    for (int k = 0; k < 5; k++) clk_bit(1'b0, s);
    bus_stop();
    chk("R9 partial data byte not written", wr_count, w0);
    bus_start();
    send_chk("R9 read ack", {MID, 1'b1});
    rd_bytes(1'b0, 1, "R9 loaded address kept");
    bus_stop();

    chk("R10 SDA stable while SCL high", viol, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule